// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter

This block sits on a processor bus and gives software two 8-bit parallel ports, A and B. Each line of a port can be an input or an output on its own. Every port has an edge input (C1) and a second control line (C2). C2 can act as an edge input. It can also be handed to a separate handshake block as an output. Software reaches four byte-wide locations through a 2-bit register select. The access is qualified by three chip selects and a read/write strobe. All bus activity is sampled on the processor clock.

For each port, one address is shared between the direction register and the data register. A bit in that port's control register decides which of the two the address reaches. Chosen edges on the control lines set sticky flags in the control register. If the matching enable bit is set, a flag pulls that port's active-low interrupt output low. Software clears both flags of a port by reading that port's data register. The control lines are asynchronous, so each passes through a two-stage synchroniser before edge detection. For each C2 line, the block exports the mode bits and one access strobe. A separate handshake block uses them to drive C2 as an output.

Top module: `dual_port_adapter`

## Requirements
- R1: An access takes place only while cs0=1, cs1=1 and cs2_n=0. The select values are: rsel=0 is the port A data or direction register, rsel=1 is control A, rsel=2 is the port B data or direction register, and rsel=3 is control B. Writes take effect at the rising clock edge. rdata shows the selected register during a read and is 0 otherwise.
- R2: Control bit 2 chooses what rsel 0 or 2 reaches: 0 selects the direction register and 1 selects the data register.
- R3: Each port output enable bit equals the matching direction bit (1 = output). Each port output value equals the data register.
- R4: A read of a data register returns the data register value on output bits and the pin value on input bits.
- R5: Control bit 1 picks the active C1 edge (1 = rising, 0 = falling). An active edge sets flag bit 7. An edge of the other polarity leaves the flag unchanged.
- R6: While control bit 5 is 0, bit 4 picks the active C2 edge (1 = rising) and an active edge sets flag bit 6. While bit 5 is 1, C2 edges set no flag.
- R7: A read of a port's data register clears both of that port's flags at that clock edge. A read of the direction register clears neither flag. An edge detected in the same cycle as the read wins.
- R8: irqa_n and irqb_n are active low. Each is 0 exactly when a flag of its own port is set with its enable bit set: bit 0 enables the bit-7 flag, and bit 3 enables the bit-6 flag while bit 5 is 0.
- R9: Synchronous active-low reset clears the direction, data and control registers and both flags. After reset all port lines are inputs and both interrupts are high.
- R10: While not selected, writes change no register.
- R11: A C1 or C2 level change applied before clock edge 1 sets its flag at edge 3, and not earlier.
- R12: Control bits 7 and 6 are read-only, and writes to them are ignored. A control read returns {flag7, flag6, bits 5:0}.
- R13: ca2_mode and cb2_mode carry control bits 5:3. pa_read_stb is 1 during a port A data-register read. pb_write_stb is 1 during a port B data-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs0 | input | 1 | Chip select, active high |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| rsel | input | 2 | Register select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| ca1 | input | 1 | Port A edge input |
| ca2_in | input | 1 | Port A second control line, input sense |
| cb1 | input | 1 | Port B edge input |
| cb2_in | input | 1 | Port B second control line, input sense |
| ca2_mode | output | 3 | Control A bits 5:3, for the handshake block |
| cb2_mode | output | 3 | Control B bits 5:3, for the handshake block |
| pa_read_stb | output | 1 | Port A data-register read in this cycle |
| pb_write_stb | output | 1 | Port B data-register write in this cycle |
| irqa_n | output | 1 | Port A interrupt, active low |
| irqb_n | output | 1 | Port B interrupt, active low |

## Verification
The assertions check on every cycle that the output enables hold still unless a direction write happened, and that no register output moves while the block is deselected. They also check that a flag rises only after a qualified edge, that a data-register read without a coincident edge leaves both flags clear, that an asserted interrupt always has a flag behind it, and that reset leaves the block idle. The directed scenarios are the only place to show the following: the values of the register decode, the mixing of pins and output bits on reads, the choice of edge polarity, the exact synchroniser latency, and that a direction-register read leaves the flags in place.

// File: rtl/dpa_pkg.sv
// Package dpa_pkg: shared widths and the register-select encoding for the
// dual-port adapter. Assumes a byte-wide bus.
package dpa_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        SEL_PORTA = 2'd0,
        SEL_CTLA  = 2'd1,
        SEL_PORTB = 2'd2,
        SEL_CTLB  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dpa_line_sync.sv
// Module dpa_line_sync: carries one asynchronous control line through a chain
// of STAGES flip-flops, then flags a rising or falling edge for one cycle.
// Assumes STAGES >= 2. The chain resets to 0, so a line held low through reset
// gives no edge.
module dpa_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/dpa_port.sv
// Module dpa_port: one port of the adapter. It holds the direction register,
// the data register, the writable control bits and the two sticky edge flags,
// and it forms the port's active-low interrupt. The parent decodes the bus and
// supplies per-port strobes. Assumes synchronised, one-cycle edge pulses.
module dpa_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_main,   // write to the shared data/direction address
    input  logic         wr_ctl,    // write to the control address
    input  logic         rd_main,   // read of the shared data/direction address
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    input  logic         c1_rise,
    input  logic         c1_fall,
    input  logic         c2_rise,
    input  logic         c2_fall,
    output logic [W-1:0] main_rd,
    output logic [7:0]   ctl_rd,
    output logic [W-1:0] port_out,
    output logic [W-1:0] port_oe,
    output logic         irq_n,
    output logic [1:0]   flags,     // {c1 flag, c2 flag}
    output logic [1:0]   evt,       // qualified edge events {c1, c2}
    output logic [2:0]   c2_mode,
    output logic         data_rd_stb,
    output logic         data_wr_stb
);
    logic [W-1:0] ddr_q;
    logic [W-1:0] out_q;
    logic [5:0]   cr_q;
    logic         f1_q;
    logic         f2_q;
    logic         sel_data;
    logic         ev1;
    logic         ev2;

    assign sel_data    = cr_q[2];
    assign data_rd_stb = rd_main & sel_data;
    assign data_wr_stb = wr_main & sel_data;

    // Qualify each raw edge by the programmed polarity and C2 direction.
    always_comb begin
        ev1 = cr_q[1] ? c1_rise : c1_fall;
        ev2 = ~cr_q[5] & (cr_q[4] ? c2_rise : c2_fall);
    end

    // Direction register: written when the shared address points at it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ddr_q <= '0;
        else if (wr_main && !sel_data) ddr_q <= wdata;
    end

    // Data register: written when the shared address points at it.
    always_ff @(posedge clk) begin
        if (!rst_n)           out_q <= '0;
        else if (data_wr_stb) out_q <= wdata;
    end

    // Writable control bits 5:0; bits 7:6 are the flags and ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      cr_q <= '0;
        else if (wr_ctl) cr_q <= wdata[5:0];
    end

    // C1 flag: set on a qualified edge, cleared by a data read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)           f1_q <= 1'b0;
        else if (ev1)         f1_q <= 1'b1;
        else if (data_rd_stb) f1_q <= 1'b0;
    end

    // C2 flag: same rule as C1, qualified by input direction.
    always_ff @(posedge clk) begin
        if (!rst_n)           f2_q <= 1'b0;
        else if (ev2)         f2_q <= 1'b1;
        else if (data_rd_stb) f2_q <= 1'b0;
    end

    // Read mux for the shared address: mixed pins/outputs or direction bits.
    always_comb begin
        if (sel_data) main_rd = (out_q & ddr_q) | (pin_in & ~ddr_q);
        else          main_rd = ddr_q;
    end

    assign ctl_rd   = {f1_q, f2_q, cr_q};
    assign port_out = out_q;
    assign port_oe  = ddr_q;
    assign flags    = {f1_q, f2_q};
    assign evt      = {ev1, ev2};
    assign c2_mode  = cr_q[5:3];
    assign irq_n    = ~((f1_q & cr_q[0]) | (f2_q & cr_q[3] & ~cr_q[5]));
endmodule

// File: rtl/dual_port_adapter.sv
// Module dual_port_adapter: top of the dual-port parallel adapter. It decodes
// the chip selects and register select into per-port strobes, synchronises
// the four control lines, instantiates both ports and muxes read data.
// Assumes bus signals are synchronous to clk and held for one cycle per access.
module dual_port_adapter
    import dpa_pkg::*;
#(
    parameter int W           = DW,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs0,
    input  logic         cs1,
    input  logic         cs2_n,
    input  logic [1:0]   rsel,
    input  logic         rd_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe,
    input  logic         ca1,
    input  logic         ca2_in,
    input  logic         cb1,
    input  logic         cb2_in,
    output logic [2:0]   ca2_mode,
    output logic [2:0]   cb2_mode,
    output logic         pa_read_stb,
    output logic         pb_write_stb,
    output logic         irqa_n,
    output logic         irqb_n
);
    localparam int NLINES = 4;

    logic              acc;
    logic              wr;
    logic              rd;
    logic [3:0]        hit;
    logic [NLINES-1:0] lines;
    logic [NLINES-1:0] l_rise;
    logic [NLINES-1:0] l_fall;
    logic [W-1:0]      main_a;
    logic [W-1:0]      main_b;
    logic [7:0]        ctl_a;
    logic [7:0]        ctl_b;
    logic [1:0]        flags_a;
    logic [1:0]        flags_b;
    logic [1:0]        evt_a;
    logic [1:0]        evt_b;
    logic              pa_wr_unused;
    logic              pb_rd_unused;
    logic              ddra_wr;

    assign acc = cs0 & cs1 & ~cs2_n;
    assign wr  = acc & ~rd_wr;
    assign rd  = acc & rd_wr;

    // One-hot register hit from the select bits.
    always_comb begin
        hit = '0;
        hit[rsel] = 1'b1;
    end

    assign ddra_wr = wr & hit[SEL_PORTA] & ~ctl_a[2];
    assign lines   = {cb2_in, cb1, ca2_in, ca1};

    // One synchroniser and edge detector per control line.
    for (genvar i = 0; i < NLINES; i++) begin : g_sync
        dpa_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_in(lines[i]),
            .rise   (l_rise[i]),
            .fall   (l_fall[i])
        );
    end

    dpa_port #(.W(W)) u_port_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_main    (wr & hit[SEL_PORTA]),
        .wr_ctl     (wr & hit[SEL_CTLA]),
        .rd_main    (rd & hit[SEL_PORTA]),
        .wdata      (wdata),
        .pin_in     (pa_in),
        .c1_rise    (l_rise[0]),
        .c1_fall    (l_fall[0]),
        .c2_rise    (l_rise[1]),
        .c2_fall    (l_fall[1]),
        .main_rd    (main_a),
        .ctl_rd     (ctl_a),
        .port_out   (pa_out),
        .port_oe    (pa_oe),
        .irq_n      (irqa_n),
        .flags      (flags_a),
        .evt        (evt_a),
        .c2_mode    (ca2_mode),
        .data_rd_stb(pa_read_stb),
        .data_wr_stb(pa_wr_unused)
    );

    dpa_port #(.W(W)) u_port_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_main    (wr & hit[SEL_PORTB]),
        .wr_ctl     (wr & hit[SEL_CTLB]),
        .rd_main    (rd & hit[SEL_PORTB]),
        .wdata      (wdata),
        .pin_in     (pb_in),
        .c1_rise    (l_rise[2]),
        .c1_fall    (l_fall[2]),
        .c2_rise    (l_rise[3]),
        .c2_fall    (l_fall[3]),
        .main_rd    (main_b),
        .ctl_rd     (ctl_b),
        .port_out   (pb_out),
        .port_oe    (pb_oe),
        .irq_n      (irqb_n),
        .flags      (flags_b),
        .evt        (evt_b),
        .c2_mode    (cb2_mode),
        .data_rd_stb(pb_rd_unused),
        .data_wr_stb(pb_write_stb)
    );

    // Read data mux: selected register during a read, zero otherwise.
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (reg_sel_e'(rsel))
                SEL_PORTA: rdata = main_a;
                SEL_CTLA:  rdata = ctl_a;
                SEL_PORTB: rdata = main_b;
                SEL_CTLB:  rdata = ctl_b;
            endcase
        end
    end
endmodule

// File: rtl/dual_port_adapter_chk.sv
// Module dual_port_adapter_chk: cycle-level properties of the adapter,
// bound into every instance of dual_port_adapter.
module dual_port_adapter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         acc,
    input logic         ddra_wr,
    input logic         pa_read_stb,
    input logic [W-1:0] pa_oe,
    input logic [W-1:0] pb_oe,
    input logic [W-1:0] pa_out,
    input logic [W-1:0] pb_out,
    input logic [1:0]   flags_a,
    input logic [1:0]   flags_b,
    input logic [1:0]   evt_a,
    input logic         irqa_n,
    input logic         irqb_n
);
    // R9: after reset is released the block is idle.
    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irqa_n && irqb_n && pa_oe == '0 && pb_oe == '0));

    // R3: port A enables move only after a direction-register write.
    assert_ddr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ddra_wr) |-> $stable(pa_oe));

    // R10: no register output changes after a deselected cycle.
    assert_idle_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc) |-> ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe)));

    // R7: a data read with no coincident edge leaves both flags clear.
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pa_read_stb) && $past(evt_a) == 2'b00) |-> flags_a == 2'b00);

    // R5: the C1 flag of port A rises only after a qualified edge.
    assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_a[1]) |-> $past(evt_a[1]));

    // R8: an asserted interrupt always has a flag of its own port behind it.
    assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irqa_n |-> flags_a != 2'b00) and (!irqb_n |-> flags_b != 2'b00));
endmodule

bind dual_port_adapter dual_port_adapter_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .ddra_wr    (ddra_wr),
    .pa_read_stb(pa_read_stb),
    .pa_oe      (pa_oe),
    .pb_oe      (pb_oe),
    .pa_out     (pa_out),
    .pb_out     (pb_out),
    .flags_a    (flags_a),
    .flags_b    (flags_b),
    .evt_a      (evt_a),
    .irqa_n     (irqa_n),
    .irqb_n     (irqb_n)
);

// File: tb/dual_port_adapter_bench.sv
// Bench dual_port_adapter_bench: directed scenarios, one task each.
// Inputs change at the falling edge, and outputs are sampled shortly after it.
module dual_port_adapter_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs0 = 1'b0, cs1 = 1'b0, cs2_n = 1'b1;
    logic [1:0] rsel = '0;
    logic       rd_wr = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_in = '0, pb_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
    logic       ca1 = 1'b0, ca2_in = 1'b0, cb1 = 1'b0, cb2_in = 1'b0;
    logic [2:0] ca2_mode, cb2_mode;
    logic       pa_read_stb, pb_write_stb, irqa_n, irqb_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_port_adapter u_dual_port_adapter (
        .clk(clk), .rst_n(rst_n), .cs0(cs0), .cs1(cs1), .cs2_n(cs2_n),
        .rsel(rsel), .rd_wr(rd_wr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .ca1(ca1), .ca2_in(ca2_in), .cb1(cb1), .cb2_in(cb2_in),
        .ca2_mode(ca2_mode), .cb2_mode(cb2_mode),
        .pa_read_stb(pa_read_stb), .pb_write_stb(pb_write_stb),
        .irqa_n(irqa_n), .irqb_n(irqb_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Bus write: called and returns at a falling edge.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
        cs0 = 1'b1; cs1 = 1'b1; cs2_n = ~sel; rsel = a; rd_wr = 1'b0; wdata = d;
        @(negedge clk);
        cs0 = 1'b0; cs1 = 1'b0; cs2_n = 1'b1; rd_wr = 1'b1;
    endtask

    // Bus read: samples before the rising edge, returns at the next falling edge.
    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        cs0 = 1'b1; cs1 = 1'b1; cs2_n = 1'b0; rsel = a; rd_wr = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        cs0 = 1'b0; cs1 = 1'b0; cs2_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R9 irqa_n", {7'd0, irqa_n}, 8'h01);
        check("R9 irqb_n", {7'd0, irqb_n}, 8'h01);
        check("R9 pa_oe", pa_oe, 8'h00);
        check("R9 pb_oe", pb_oe, 8'h00);
        bus_read(2'd1, v); check("R9 ctl A", v, 8'h00);
        bus_read(2'd0, v); check("R9 ddr A", v, 8'h00);
        check("R1 idle rdata", rdata, 8'h00);
    endtask

    task automatic t_ports();
        logic [7:0] v;
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'hF0);
        check("R3 pa_oe", pa_oe, 8'hF0);
        bus_write(2'd1, 8'h04);
        bus_write(2'd0, 8'hA5);
        check("R2 pa_out", pa_out, 8'hA5);
        check("R2 ddr untouched", pa_oe, 8'hF0);
        pa_in = 8'h3C;
        bus_read(2'd0, v); check("R4 port A read", v, 8'hAC);
        bus_write(2'd1, 8'h00);
        bus_read(2'd0, v); check("R2 ddr A read", v, 8'hF0);
        bus_write(2'd1, 8'h04);
        bus_write(2'd3, 8'h00);
        bus_write(2'd2, 8'h0F);
        check("R3 pb_oe", pb_oe, 8'h0F);
        bus_write(2'd3, 8'h04);
        cs0 = 1'b1; cs1 = 1'b1; cs2_n = 1'b0; rsel = 2'd2; rd_wr = 1'b0; wdata = 8'h66;
        #1 check("R13 pb_write_stb", {7'd0, pb_write_stb}, 8'h01);
        @(negedge clk);
        cs0 = 1'b0; cs1 = 1'b0; cs2_n = 1'b1; rd_wr = 1'b1;
        pb_in = 8'h90;
        bus_read(2'd2, v); check("R4 port B read", v, 8'h96);
        bus_read(2'd3, v); check("R1 ctl B read", v, 8'h04);
    endtask

    task automatic t_chip_select();
        bus_write(2'd0, 8'h00, 1'b0);
        check("R10 pa_out held", pa_out, 8'hA5);
        bus_write(2'd3, 8'h3F, 1'b0);
        check("R10 cb2_mode held", {5'd0, cb2_mode}, 8'h00);
    endtask

    task automatic t_c1_edges();
        logic [7:0] v;
        bus_write(2'd1, 8'h07);
        ca1 = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_read(2'd1, v); check("R11 flag not yet", v, 8'h07);
        bus_read(2'd1, v); check("R11 flag at edge 3", v, 8'h87);
        check("R8 irqa_n low", {7'd0, irqa_n}, 8'h00);
        check("R8 irqb_n high", {7'd0, irqb_n}, 8'h01);
        bus_write(2'd1, 8'hC7);
        bus_read(2'd1, v); check("R12 ro flags kept", v, 8'h87);
        cs0 = 1'b1; cs1 = 1'b1; cs2_n = 1'b0; rsel = 2'd0; rd_wr = 1'b1;
        #1 check("R13 pa_read_stb", {7'd0, pa_read_stb}, 8'h01);
        @(negedge clk);
        cs0 = 1'b0; cs1 = 1'b0; cs2_n = 1'b1;
        bus_read(2'd1, v); check("R7 cleared by read", v, 8'h07);
        check("R8 irqa_n released", {7'd0, irqa_n}, 8'h01);
        ca1 = 1'b0; idle(5);
        bus_read(2'd1, v); check("R5 wrong edge ignored", v, 8'h07);
        bus_write(2'd1, 8'hC5);
        bus_read(2'd1, v); check("R12 ro bits write", v, 8'h05);
        ca1 = 1'b1; idle(5); ca1 = 1'b0; idle(5);
        bus_read(2'd1, v); check("R5 falling edge", v, 8'h85);
        bus_write(2'd1, 8'h01);
        bus_read(2'd0, v);
        bus_read(2'd1, v); check("R7 ddr read keeps flag", v, 8'h81);
        bus_write(2'd1, 8'h05);
        bus_read(2'd0, v);
    endtask

    task automatic t_c2_edges();
        logic [7:0] v;
        bus_write(2'd1, 8'h0C);
        ca2_in = 1'b1; idle(5);
        bus_read(2'd1, v); check("R6 rising ignored", v, 8'h0C);
        ca2_in = 1'b0; idle(5);
        bus_read(2'd1, v); check("R6 falling sets", v, 8'h4C);
        check("R8 c2 irq", {7'd0, irqa_n}, 8'h00);
        bus_read(2'd0, v);
        bus_read(2'd1, v); check("R7 c2 cleared", v, 8'h0C);
        bus_write(2'd1, 8'h3C);
        check("R13 ca2_mode", {5'd0, ca2_mode}, 8'h07);
        ca2_in = 1'b1; idle(5); ca2_in = 1'b0; idle(5);
        bus_read(2'd1, v); check("R6 output mode no flag", v, 8'h3C);
        check("R8 no irq", {7'd0, irqa_n}, 8'h01);
    endtask

    task automatic t_port_b_irq();
        logic [7:0] v;
        bus_write(2'd3, 8'h05);
        cb1 = 1'b1; idle(5); cb1 = 1'b0; idle(5);
        check("R8 irqb_n low", {7'd0, irqb_n}, 8'h00);
        check("R8 irqa_n stays", {7'd0, irqa_n}, 8'h01);
        bus_read(2'd3, v); check("R5 port B flag", v, 8'h85);
        bus_read(2'd2, v);
        check("R7 port B clear irq", {7'd0, irqb_n}, 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ports();
        t_chip_select();
        t_c1_edges();
        t_c2_edges();
        t_port_b_irq();
        summary();
    end
endmodule